// File: doc/BRIEF.md
# Dual-Lane Integer Multiply-Accumulate Unit

This unit carries out the 32-bit integer multiply and multiply-add work of a 64-bit core. It has two independent accumulator lanes. Each lane holds a 64-bit HI and a 64-bit LO register. Lane 0 forms bits 63:0 of a 128-bit HI/LO pair, and lane 1 forms bits 127:64. The base instructions address lane 0. The "pipeline 1" variants address lane 1.

The core presents one instruction word per cycle, together with the values of its two source registers. A multiply or multiply-add occupies its lane for a fixed number of cycles, set by a parameter. While a lane is occupied, any instruction that targets that lane is held off through `stall`. An instruction for the other lane is accepted and runs alongside. Multiplies that name a destination register also return the sign-extended low word of the result. Moves from HI or LO return the full 64-bit lane register. Both kinds of result leave on the lane's own write-back port, so the two lanes never compete for one port.

Top module: `mac_dual_lane`

## Requirements
- R1: After reset, all four accumulator registers read as zero, no write-back port is active, `stall` is low and both `lane_busy` bits are low.
- R2: The decoder recognises only the following encodings. An opcode field (bits 31:26) of 0 selects lane 0 with function field (bits 5:0) 0x18 signed multiply, 0x19 unsigned multiply, 0x10 read HI, 0x11 write HI, 0x12 read LO and 0x13 write LO. An opcode of 0x1C selects 0x00 signed multiply-add and 0x01 unsigned multiply-add on lane 0. Under opcode 0x1C, the codes 0x18/0x19 (multiply), 0x20/0x21 (multiply-add) and 0x10-0x13 (the HI/LO moves) act on lane 1. Any other word is accepted but changes no state and writes nothing.
- R3: A signed multiply takes bits 31:0 of each operand as two's-complement values and ignores bits 63:32. The low 32 bits of the 64-bit product, sign-extended, go to LO. The high 32 bits, sign-extended, go to HI.
- R4: An unsigned multiply zero-extends bits 31:0 of each operand. It places the product halves in LO and HI, each sign-extended from its bit 31.
- R5: A multiply-add adds the product to the 64-bit value {HI[31:0], LO[31:0]} and ignores the upper halves of both registers. It writes the sum back as two sign-extended 32-bit halves.
- R6: Lane 1 instructions read and write only lane 1, and lane 0 instructions read and write only lane 0.
- R7: A multiply or multiply-add with rd (bits 15:11) non-zero pulses the lane's write enable for one cycle, exactly `MUL_LAT` cycles after acceptance. The pulse carries rd and the new LO value. With rd zero, no write-back occurs.
- R8: Writing HI or LO stores the full 64-bit rs value. Reading HI or LO returns the full 64-bit register on the lane's port, one cycle after acceptance, when rd is non-zero.
- R9: A lane's busy flag is high for exactly `MUL_LAT` cycles after a multiply or multiply-add is accepted on it. A recognised instruction for a busy lane raises `stall` and is not accepted. An instruction for an idle lane is accepted while the other lane is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| rs_val | input | 64 | Value of source register rs |
| rt_val | input | 64 | Value of source register rt |
| stall | output | 1 | Presented instruction targets a busy lane and is not taken |
| lane_busy | output | 2 | Per-lane multiply in progress |
| wb_we | output | 2 | Per-lane register write enable |
| wb_idx | output | 10 | Per-lane destination register, 5 bits per lane, lane 0 in bits 4:0 |
| wb_data | output | 128 | Per-lane write data, lane 0 in bits 63:0 |

## Verification
The bench builds the unit with `MUL_LAT` set to 4, one above the default. This makes each busy window long enough to see three things in turn. First, an instruction for the other lane is accepted in the cycle after a multiply. Second, a HI/LO read on the busy lane is held for several cycles. Third, the write-back lands exactly at the end of the window. A latency of 4 also takes the countdown past the default width, so a counter sized from the parameter is exercised beyond a single bit.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam logic [5:0] PRIM_BASE = 6'h00;
  localparam logic [5:0] PRIM_EXT  = 6'h1C;

  localparam logic [5:0] FN_MUL_S  = 6'h18;
  localparam logic [5:0] FN_MUL_U  = 6'h19;
  localparam logic [5:0] FN_RD_HI  = 6'h10;
  localparam logic [5:0] FN_WR_HI  = 6'h11;
  localparam logic [5:0] FN_RD_LO  = 6'h12;
  localparam logic [5:0] FN_WR_LO  = 6'h13;
  localparam logic [5:0] FN_MAC_S0 = 6'h00;
  localparam logic [5:0] FN_MAC_U0 = 6'h01;
  localparam logic [5:0] FN_MAC_S1 = 6'h20;
  localparam logic [5:0] FN_MAC_U1 = 6'h21;

  typedef enum logic [2:0] {
    OP_NONE, OP_MUL, OP_MADD, OP_MFHI, OP_MFLO, OP_MTHI, OP_MTLO
  } op_kind_e;

  typedef struct packed {
    logic       lane;
    op_kind_e   kind;
    logic       sgn;
    logic [4:0] rd;
  } dec_t;

  // Sign-extend a 32-bit word to 64 bits.
  function automatic logic [63:0] sext_word(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // 32x32 product in 64 bits. Both operands are widened to 64 bits first,
  // so the low 64 bits of the product are exact in either signedness.
  function automatic logic [63:0] word_product(input logic [31:0] a,
                                               input logic [31:0] b,
                                               input logic sgn);
    logic [63:0] ea;
    logic [63:0] eb;
    ea = sgn ? sext_word(a) : {32'b0, a};
    eb = sgn ? sext_word(b) : {32'b0, b};
    return ea * eb;
  endfunction

  // Split a 64-bit sum into sign-extended halves, returned as {hi, lo}.
  function automatic logic [127:0] fold_halves(input logic [63:0] s);
    return {sext_word(s[63:32]), sext_word(s[31:0])};
  endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);

  logic [5:0] prim;
  logic [5:0] fn;
  logic       unused_fields;

  assign prim          = insn[31:26];
  assign fn            = insn[5:0];
  assign unused_fields = ^{insn[25:16], insn[10:6]};

  always_comb begin
    dec      = '0;
    dec.kind = OP_NONE;
    dec.rd   = insn[15:11];
    if (prim == PRIM_BASE) begin
      dec.lane = 1'b0;
      unique case (fn)
        FN_MUL_S: begin dec.kind = OP_MUL; dec.sgn = 1'b1; end
        FN_MUL_U: dec.kind = OP_MUL;
        FN_RD_HI: dec.kind = OP_MFHI;
        FN_WR_HI: dec.kind = OP_MTHI;
        FN_RD_LO: dec.kind = OP_MFLO;
        FN_WR_LO: dec.kind = OP_MTLO;
        default:  dec.kind = OP_NONE;
      endcase
    end else if (prim == PRIM_EXT) begin
      unique case (fn)
        FN_MAC_S0: begin dec.kind = OP_MADD; dec.sgn = 1'b1; dec.lane = 1'b0; end
        FN_MAC_U0: begin dec.kind = OP_MADD; dec.lane = 1'b0; end
        FN_MUL_S:  begin dec.kind = OP_MUL;  dec.sgn = 1'b1; dec.lane = 1'b1; end
        FN_MUL_U:  begin dec.kind = OP_MUL;  dec.lane = 1'b1; end
        FN_MAC_S1: begin dec.kind = OP_MADD; dec.sgn = 1'b1; dec.lane = 1'b1; end
        FN_MAC_U1: begin dec.kind = OP_MADD; dec.lane = 1'b1; end
        FN_RD_HI:  begin dec.kind = OP_MFHI; dec.lane = 1'b1; end
        FN_WR_HI:  begin dec.kind = OP_MTHI; dec.lane = 1'b1; end
        FN_RD_LO:  begin dec.kind = OP_MFLO; dec.lane = 1'b1; end
        FN_WR_LO:  begin dec.kind = OP_MTLO; dec.lane = 1'b1; end
        default:   dec.kind = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_pkg::*;
#(
  parameter int MUL_LAT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  dec_t        dec,
  input  logic [63:0] rs_val,
  input  logic [31:0] rt_word,
  output logic        busy,
  output logic        commit,
  output logic        wb_we,
  output logic [4:0]  wb_idx,
  output logic [63:0] wb_data
);

  localparam int CW = $clog2(MUL_LAT + 1);

  logic [CW-1:0] cnt;
  logic [63:0]   hi_q, lo_q, pend_hi, pend_lo;
  logic [4:0]    pend_rd;
  logic [63:0]   prod, sum;
  logic [127:0]  folded;
  logic          unused_lane;

  assign unused_lane = dec.lane;

  // Arithmetic for the incoming operation. The lane's HI/LO cannot change
  // while a multiply is pending, so the addend is taken here at acceptance.
  always_comb begin
    prod   = word_product(rs_val[31:0], rt_word, dec.sgn);
    sum    = (dec.kind == OP_MADD) ? prod + {hi_q[31:0], lo_q[31:0]} : prod;
    folded = fold_halves(sum);
  end

  assign busy   = (cnt != '0);
  assign commit = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      pend_hi <= '0;
      pend_lo <= '0;
      pend_rd <= '0;
      wb_we   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_we <= 1'b0;
      if (accept) begin
        unique case (dec.kind)
          OP_MUL, OP_MADD: begin
            pend_hi <= folded[127:64];
            pend_lo <= folded[63:0];
            pend_rd <= dec.rd;
            cnt     <= CW'(MUL_LAT);
          end
          OP_MFHI: begin
            wb_we   <= (dec.rd != '0);
            wb_idx  <= dec.rd;
            wb_data <= hi_q;
          end
          OP_MFLO: begin
            wb_we   <= (dec.rd != '0);
            wb_idx  <= dec.rd;
            wb_data <= lo_q;
          end
          OP_MTHI: hi_q <= rs_val;
          OP_MTLO: lo_q <= rs_val;
          default: ;
        endcase
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (commit) begin
          hi_q    <= pend_hi;
          lo_q    <= pend_lo;
          wb_we   <= (pend_rd != '0);
          wb_idx  <= pend_rd;
          wb_data <= pend_lo;
        end
      end
    end
  end

endmodule

// File: rtl/mac_dual_lane.sv
module mac_dual_lane
  import mac_pkg::*;
#(
  parameter int MUL_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [31:0]   insn,
  input  logic [63:0]   rs_val,
  input  logic [63:0]   rt_val,
  output logic          stall,
  output logic [1:0]    lane_busy,
  output logic [1:0]    wb_we,
  output logic [9:0]    wb_idx,
  output logic [127:0]  wb_data
);

  localparam int LANES = 2;
  localparam int IDX_W = 5;
  localparam int DAT_W = 64;

  dec_t             dec;
  logic             recognised;
  logic [LANES-1:0] lane_accept;
  logic [LANES-1:0] lane_commit;
  logic             unused_rt_hi;

  assign unused_rt_hi = ^rt_val[63:32];

  mac_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  assign recognised = insn_valid && (dec.kind != OP_NONE);
  assign stall      = recognised && lane_busy[dec.lane];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_accept[g] = recognised && (dec.lane == 1'(g)) && !lane_busy[g];

    mac_lane #(.MUL_LAT(MUL_LAT)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (lane_accept[g]),
      .dec     (dec),
      .rs_val  (rs_val),
      .rt_word (rt_val[31:0]),
      .busy    (lane_busy[g]),
      .commit  (lane_commit[g]),
      .wb_we   (wb_we[g]),
      .wb_idx  (wb_idx[g*IDX_W +: IDX_W]),
      .wb_data (wb_data[g*DAT_W +: DAT_W])
    );
  end

endmodule

// File: rtl/mac_checker.sv
module mac_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [1:0] lane_busy,
  input logic [1:0] lane_commit,
  input logic [1:0] wb_we,
  input logic [9:0] wb_idx
);

  AST_STALL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (lane_busy != 2'b00)); // R9

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lane_busy[g] && !lane_commit[g] |=> lane_busy[g]); // R9

    AST_COMMIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      lane_commit[g] |=> !lane_busy[g]); // R9

    AST_WB_NONZERO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we[g] |-> (wb_idx[g*5 +: 5] != 5'd0)); // R7
  end

endmodule

bind mac_dual_lane mac_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stall       (stall),
  .lane_busy   (lane_busy),
  .lane_commit (lane_commit),
  .wb_we       (wb_we),
  .wb_idx      (wb_idx)
);

// File: tb/sim_mac_dual_lane.sv
`timescale 1ns/1ps
module sim_mac_dual_lane;

  localparam int LAT = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         insn_valid;
  logic [31:0]  insn;
  logic [63:0]  rs_val, rt_val;
  logic         stall;
  logic [1:0]   lane_busy, wb_we;
  logic [9:0]   wb_idx;
  logic [127:0] wb_data;

  always #4 clk = ~clk;

  mac_dual_lane #(.MUL_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rs_val(rs_val), .rt_val(rt_val), .stall(stall), .lane_busy(lane_busy),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int vectors = 0;
  int misses  = 0;

  // Behavioural model state
  longint unsigned m_hi[2], m_lo[2], p_hi[2], p_lo[2], e_data[2];
  int              remain[2], p_rd[2], e_idx[2];
  bit              e_we[2];
  string           l_tag[2];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int rd, input int fn);
    return {6'(op), 10'b0, 5'(rd), 5'b0, 6'(fn)};
  endfunction

  // kind: 0 none, 1 multiply, 2 multiply-add, 3 read HI, 4 read LO, 5 write HI, 6 write LO
  task automatic bdec(input logic [31:0] w, output int kind, output int lane, output bit sg);
    int op;
    int fn;
    op = int'(w[31:26]);
    fn = int'(w[5:0]);
    kind = 0; lane = 0; sg = 0;
    if (op == 0) begin
      case (fn)
        24: begin kind = 1; sg = 1; end
        25: kind = 1;
        16: kind = 3;
        18: kind = 4;
        17: kind = 5;
        19: kind = 6;
        default: kind = 0;
      endcase
    end else if (op == 28) begin
      case (fn)
        0:  begin kind = 2; sg = 1; end
        1:  kind = 2;
        24: begin kind = 1; sg = 1; lane = 1; end
        25: begin kind = 1; lane = 1; end
        32: begin kind = 2; sg = 1; lane = 1; end
        33: begin kind = 2; lane = 1; end
        16: begin kind = 3; lane = 1; end
        18: begin kind = 4; lane = 1; end
        17: begin kind = 5; lane = 1; end
        19: begin kind = 6; lane = 1; end
        default: kind = 0;
      endcase
    end
  endtask

  task automatic cycle(input bit v, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input string tag, output bit acc);
    int kind, lane;
    bit sg, es;
    longint unsigned s;
    insn_valid = v; insn = w; rs_val = a; rt_val = b;
    bdec(w, kind, lane, sg);
    es = v && (kind != 0) && (remain[lane] != 0);
    #1;
    check(stall == es, "R9", "stall", longint'(stall), longint'(es));
    for (int g = 0; g < 2; g++)
      check(lane_busy[g] == (remain[g] != 0), "R9", "lane_busy",
            longint'(lane_busy[g]), longint'(remain[g] != 0));
    @(posedge clk);
    acc = v && !es;
    for (int g = 0; g < 2; g++) begin
      e_we[g] = 0;
      if (acc && kind != 0 && lane == g) begin
        case (kind)
          1, 2: begin
            if (sg) s = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
            else    s = longint'({32'b0, a[31:0]}) * longint'({32'b0, b[31:0]});
            if (kind == 2) s = s + {m_hi[g][31:0], m_lo[g][31:0]};
            p_lo[g] = longint'(int'(s[31:0]));
            p_hi[g] = longint'(int'(s[63:32]));
            p_rd[g] = int'(w[15:11]);
            remain[g] = LAT;
            l_tag[g] = tag;
          end
          3: begin e_we[g] = (w[15:11] != 0); e_idx[g] = int'(w[15:11]); e_data[g] = m_hi[g]; l_tag[g] = tag; end
          4: begin e_we[g] = (w[15:11] != 0); e_idx[g] = int'(w[15:11]); e_data[g] = m_lo[g]; l_tag[g] = tag; end
          5: m_hi[g] = a;
          6: m_lo[g] = a;
          default: ;
        endcase
      end else if (remain[g] > 0) begin
        remain[g]--;
        if (remain[g] == 0) begin
          m_hi[g] = p_hi[g];
          m_lo[g] = p_lo[g];
          e_we[g] = (p_rd[g] != 0);
          e_idx[g] = p_rd[g];
          e_data[g] = p_lo[g];
        end
      end
    end
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      check(wb_we[g] == e_we[g], l_tag[g], "wb_we", longint'(wb_we[g]), longint'(e_we[g]));
      if (e_we[g]) begin
        check(int'(wb_idx[g*5 +: 5]) == e_idx[g], l_tag[g], "wb_idx",
              longint'(wb_idx[g*5 +: 5]), longint'(e_idx[g]));
        check(wb_data[g*64 +: 64] == e_data[g], l_tag[g], "wb_data",
              wb_data[g*64 +: 64], e_data[g]);
      end
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    bit acc;
    do cycle(1'b1, w, a, b, tag, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 32'h0, 64'h0, 64'h0, "R9", acc);
  endtask

  initial begin
    #1600000;
    misses++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int g = 0; g < 2; g++) begin
      m_hi[g] = 0; m_lo[g] = 0; p_hi[g] = 0; p_lo[g] = 0; remain[g] = 0;
      p_rd[g] = 0; e_we[g] = 0; e_idx[g] = 0; e_data[g] = 0; l_tag[g] = "R1";
    end
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; rs_val = '0; rt_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: quiet outputs after reset, zero accumulators
    check(stall == 1'b0, "R1", "stall", longint'(stall), 0);
    check(wb_we == 2'b00, "R1", "wb_we", longint'(wb_we), 0);
    check(lane_busy == 2'b00, "R1", "lane_busy", longint'(lane_busy), 0);
    @(negedge clk);
    issue(enc(0, 1, 16), 0, 0, "R1");
    issue(enc(28, 2, 18), 0, 0, "R1");

    // R8: full-width moves on both lanes
    issue(enc(0, 0, 17), 64'h0123456789abcdef, 0, "R8");
    issue(enc(0, 0, 19), 64'hfedcba9876543210, 0, "R8");
    issue(enc(28, 0, 17), 64'h5a5a5a5a_a5a5a5a5, 0, "R8");
    issue(enc(28, 0, 19), 64'h0f0f0f0f_f0f0f0f0, 0, "R8");
    issue(enc(0, 4, 16), 0, 0, "R8");
    issue(enc(0, 5, 18), 0, 0, "R8");
    issue(enc(28, 6, 16), 0, 0, "R8");
    issue(enc(28, 7, 18), 0, 0, "R8");

    // R3: signed multiply with garbage upper operand bits, two-operand form
    issue(enc(0, 0, 24), 64'hdeadbeef_fffffffb, 64'h12345678_00000007, "R3");
    issue(enc(0, 8, 16), 0, 0, "R3");
    issue(enc(0, 9, 18), 0, 0, "R3");
    // R7 three-operand form, R3 most negative operands
    issue(enc(0, 3, 24), 64'h80000000, 64'hffffffff_80000000, "R7");
    issue(enc(0, 10, 16), 0, 0, "R3");

    // R4: unsigned all-ones
    issue(enc(0, 6, 25), 64'hffffffff_ffffffff, 64'h00000000_ffffffff, "R4");
    issue(enc(0, 11, 16), 0, 0, "R4");

    // R5: multiply-add ignores upper halves of HI and LO
    issue(enc(0, 0, 17), 64'haaaa5555_00000001, 0, "R5");
    issue(enc(0, 0, 19), 64'h12345678_80000000, 0, "R5");
    issue(enc(28, 7, 0), 64'h3, 64'hfffffffe, "R5");
    issue(enc(0, 12, 16), 0, 0, "R5");
    issue(enc(0, 0, 17), 64'hffffffff_7fffffff, 0, "R5");
    issue(enc(28, 13, 1), 64'hffffffff, 64'hffffffff, "R5");
    issue(enc(0, 14, 16), 0, 0, "R5");

    // R6: lane 1 arithmetic leaves lane 0 untouched
    issue(enc(28, 8, 24), 64'h7fffffff, 64'h7fffffff, "R6");
    issue(enc(28, 9, 32), 64'h80000000, 64'h2, "R6");
    issue(enc(28, 0, 33), 64'hffffffff, 64'h10, "R6");
    issue(enc(28, 15, 16), 0, 0, "R6");
    issue(enc(28, 16, 18), 0, 0, "R6");
    issue(enc(0, 17, 16), 0, 0, "R6");
    issue(enc(0, 18, 18), 0, 0, "R6");

    // R9: lanes overlap; a read on the busy lane waits
    issue(enc(0, 10, 24), 64'h1234, 64'h5678, "R9");
    issue(enc(28, 11, 25), 64'h9abc, 64'hdef0, "R9");
    issue(enc(0, 19, 18), 0, 0, "R9");
    issue(enc(28, 20, 18), 0, 0, "R9");

    // R2: unrecognised words change nothing
    issue(enc(0, 12, 32), 64'hffff_ffff, 64'hffff_ffff, "R2");
    issue(enc(1, 13, 24), 64'h55, 64'h66, "R2");
    issue(enc(28, 13, 2), 64'h55, 64'h66, "R2");
    idle(LAT + 1);
    issue(enc(0, 21, 18), 0, 0, "R2");
    issue(enc(28, 22, 16), 0, 0, "R2");

    // R7: rd of zero suppresses the write-back
    issue(enc(0, 0, 25), 64'h10, 64'h20, "R7");
    idle(LAT + 2);
    issue(enc(0, 0, 18), 0, 0, "R7");
    issue(enc(0, 23, 18), 0, 0, "R7");
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule